// File: doc/BRIEF.md
# Processor Memory Transaction Queue

This block sits between a processor core and a DRAM controller. It accepts memory requests on a valid/ready port and keeps them until the controller takes them. Each request is a posted write of up to 16 bytes with byte enables, or a read of 32 bytes. Writes have their own pool of eight slots. Reads come from four requesters, and each requester has a fixed number of outstanding slots: four for data-cache line loads, two for instruction prefetch, one for the instruction-side table walk and one for the data-side table walk. A read slot stays in use from the moment the read is accepted until its last data beat has been handed back.

On the controller side, the block offers the oldest pending entry as a single stream in arrival order. The controller returns read data in 4-byte beats, tagged with the requester. The block passes those beats on to the core, marks the eighth beat of each read as the last one, and frees the requester's slot at that point.

Back-pressure rules are as follows. A request is accepted on a cycle where req_valid and req_ready are both high. req_ready depends on req_write, req_src and req_addr, so the core must hold these stable while it waits. The dispatch stream holds its payload while dsp_ready is low. The response path is combinational in both directions: rsp_valid follows ctl_rsp_valid and ctl_rsp_ready follows rsp_ready.

Top module: `cpu_txn_queue`

## Requirements
- R1: After reset, a write request sees req_ready high, a read request from any source sees req_ready high, and dsp_valid is low.
- R2: At most eight writes are held. When eight writes are queued and not yet dispatched, req_ready is low for a write request. A write slot becomes free on the cycle after that write is dispatched.
- R3: Reads are limited per source. The source encoding is 0 for data-cache load (quota 4), 1 for instruction prefetch (quota 2), 2 for instruction table walk (quota 1) and 3 for data table walk (quota 1). req_ready is low for a read whose source already has its quota outstanding.
- R4: Each read returns as eight 4-byte beats. rsp_last is high on the eighth beat received for that source. The source's slot is freed by the handshake on that beat.
- R5: A source-0 read whose line address (req_addr bits above bit 4) matches an outstanding source-0 read sees req_ready low.
- R6: Entries are dispatched in the order they were accepted, with write flag, source, address, data and byte enables unchanged. A read that follows a write to the same address is therefore never dispatched before that write.
- R7: dsp_beats is 4 for a write and 8 for a read. A dispatched read carries all-zero dsp_wdata and dsp_be.
- R8: While dsp_valid is high and dsp_ready is low, the dispatch payload and dsp_valid stay unchanged on the next cycle.
- R9: rsp_valid, rsp_data and rsp_src equal ctl_rsp_valid, ctl_rsp_data and ctl_rsp_src, and ctl_rsp_ready equals rsp_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = posted write, 0 = read |
| req_src | input | 2 | Requester tag |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WR_BYTES*8 | Write data |
| req_be | input | WR_BYTES | Write byte enables |
| dsp_valid | output | 1 | Oldest entry offered to controller |
| dsp_ready | input | 1 | Controller takes the entry |
| dsp_write | output | 1 | Entry is a write |
| dsp_src | output | 2 | Entry source tag |
| dsp_addr | output | ADDR_W | Entry address |
| dsp_wdata | output | WR_BYTES*8 | Entry write data |
| dsp_be | output | WR_BYTES | Entry byte enables |
| dsp_beats | output | clog2(RD_BYTES/BEAT_BYTES+1) | Transfer length in 4-byte beats |
| ctl_rsp_valid | input | 1 | Controller read beat valid |
| ctl_rsp_ready | output | 1 | Read beat accepted |
| ctl_rsp_data | input | BEAT_BYTES*8 | Read beat data |
| ctl_rsp_src | input | 2 | Read beat source tag |
| rsp_valid | output | 1 | Read beat to core |
| rsp_ready | input | 1 | Core accepts beat |
| rsp_data | output | BEAT_BYTES*8 | Read beat data |
| rsp_src | output | 2 | Read beat source tag |
| rsp_last | output | 1 | Final beat of a read |

## Verification
On every cycle, the assertions check that the write count never passes eight, that no source's outstanding reads pass its quota, that a freed slot always had a read behind it, that no accepted data-cache load shares a line with an outstanding one, that the order store never overflows, and that a stalled dispatch holds its payload. Other properties need a reference model and can only be shown by the bench's scenarios. These are the exact arrival order of dispatched entries, the payload content, when ready drops and comes back as slots fill and drain, and which beat is flagged as the last of each read.

// File: rtl/ctq_pkg.sv
`timescale 1ns/1ps
package ctq_pkg;
  localparam int NSRC  = 4;
  localparam int SRC_W = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_DLOAD = 2'd0,
    SRC_IPREF = 2'd1,
    SRC_IWALK = 2'd2,
    SRC_DWALK = 2'd3
  } src_e;

  function automatic int src_quota(input int s);
    case (s)
      0:       return 4;
      1:       return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int quota_total();
    int t;
    t = 0;
    for (int s = 0; s < NSRC; s++) t += src_quota(s);
    return t;
  endfunction
endpackage

// File: rtl/ctq_order_fifo.sv
`timescale 1ns/1ps
module ctq_order_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nempty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign nempty = (cnt != '0);
  assign full   = (cnt == CW'(DEPTH));
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  // R6
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> !full);
endmodule

// File: rtl/ctq_read_credit.sv
`timescale 1ns/1ps
module ctq_read_credit #(
  parameter int RD_BEATS = 8,
  parameter int CW       = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc,
  input  logic [ctq_pkg::SRC_W-1:0] acc_src,
  input  logic                     rsp_fire,
  input  logic [ctq_pkg::SRC_W-1:0] rsp_src,
  output logic [ctq_pkg::NSRC-1:0] room,
  output logic                     last
);
  localparam int NSRC = ctq_pkg::NSRC;
  localparam int BW   = (RD_BEATS > 1) ? $clog2(RD_BEATS) : 1;

  logic [BW-1:0] bcnt [NSRC];
  logic [CW-1:0] cnt  [NSRC];

  assign last = (bcnt[rsp_src] == BW'(RD_BEATS - 1));

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int Q = ctq_pkg::src_quota(s);
    logic inc, hit, dec;
    assign inc = acc && (acc_src == ctq_pkg::SRC_W'(s));
    assign hit = rsp_fire && (rsp_src == ctq_pkg::SRC_W'(s));
    assign dec = hit && (bcnt[s] == BW'(RD_BEATS - 1));
    assign room[s] = (cnt[s] < CW'(Q));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[s]  <= '0;
        bcnt[s] <= '0;
      end else begin
        cnt[s] <= cnt[s] + CW'(inc) - CW'(dec);
        if (hit) bcnt[s] <= dec ? '0 : bcnt[s] + 1'b1;
      end
    end

    // R3
    quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[s] <= CW'(Q));
    // R4
    credit_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt[s] != '0));
  end
endmodule

// File: rtl/ctq_line_track.sv
`timescale 1ns/1ps
module ctq_line_track #(
  parameter int LW    = 27,
  parameter int SLOTS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [LW-1:0] alloc_line,
  input  logic          free,
  input  logic [LW-1:0] probe_line,
  output logic          hit
);
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [LW-1:0]    lines [SLOTS];
  logic [SLOTS-1:0] vld;
  logic [PW-1:0]    wp, rp;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      if (vld[i] && lines[i] == probe_line) hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (alloc) lines[wp] <= alloc_line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      wp  <= '0;
      rp  <= '0;
    end else begin
      if (free) begin
        vld[rp] <= 1'b0;
        rp <= (rp == PW'(SLOTS - 1)) ? '0 : rp + 1'b1;
      end
      if (alloc) begin
        vld[wp] <= 1'b1;
        wp <= (wp == PW'(SLOTS - 1)) ? '0 : wp + 1'b1;
      end
    end
  end

  // R5
  dload_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && probe_line == alloc_line) |-> !hit);
endmodule

// File: rtl/cpu_txn_queue.sv
`timescale 1ns/1ps
module cpu_txn_queue #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 4,
  parameter int WR_BYTES   = 16,
  parameter int RD_BYTES   = 32,
  parameter int WR_SLOTS   = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req_valid,
  output logic                                      req_ready,
  input  logic                                      req_write,
  input  logic [1:0]                                req_src,
  input  logic [ADDR_W-1:0]                         req_addr,
  input  logic [WR_BYTES*8-1:0]                     req_wdata,
  input  logic [WR_BYTES-1:0]                       req_be,
  output logic                                      dsp_valid,
  input  logic                                      dsp_ready,
  output logic                                      dsp_write,
  output logic [1:0]                                dsp_src,
  output logic [ADDR_W-1:0]                         dsp_addr,
  output logic [WR_BYTES*8-1:0]                     dsp_wdata,
  output logic [WR_BYTES-1:0]                       dsp_be,
  output logic [$clog2(RD_BYTES/BEAT_BYTES+1)-1:0]  dsp_beats,
  input  logic                                      ctl_rsp_valid,
  output logic                                      ctl_rsp_ready,
  input  logic [BEAT_BYTES*8-1:0]                   ctl_rsp_data,
  input  logic [1:0]                                ctl_rsp_src,
  output logic                                      rsp_valid,
  input  logic                                      rsp_ready,
  output logic [BEAT_BYTES*8-1:0]                   rsp_data,
  output logic [1:0]                                rsp_src,
  output logic                                      rsp_last
);
  import ctq_pkg::*;

  localparam int WD_W     = WR_BYTES * 8;
  localparam int WR_BEATS = WR_BYTES / BEAT_BYTES;
  localparam int RD_BEATS = RD_BYTES / BEAT_BYTES;
  localparam int LEN_W    = $clog2(RD_BEATS + 1);
  localparam int RD_SLOTS = quota_total();
  localparam int DEPTH    = WR_SLOTS + RD_SLOTS;
  localparam int LINE_SH  = $clog2(LINE_BYTES);
  localparam int LW       = ADDR_W - LINE_SH;
  localparam int ENT_W    = 1 + SRC_W + ADDR_W + WD_W + WR_BYTES;
  localparam int WCW      = $clog2(WR_SLOTS + 1);
  localparam int RCW      = $clog2(src_quota(0) + 1);

  logic [WCW-1:0]     wcnt;
  logic [NSRC-1:0]    room;
  logic               line_hit, rd_ok, wr_ok;
  logic               acc, acc_w, acc_r, pop, pop_w, rsp_fire;
  logic               last_beat, free_line;
  logic [ENT_W-1:0]   pdata, head;
  logic               nempty, full;

  // request side acceptance
  assign wr_ok     = (wcnt < WCW'(WR_SLOTS));
  assign rd_ok     = room[req_src] && !(req_src == SRC_DLOAD && line_hit);
  assign req_ready = req_write ? wr_ok : rd_ok;
  assign acc       = req_valid && req_ready;
  assign acc_w     = acc && req_write;
  assign acc_r     = acc && !req_write;

  assign pdata = {req_write, req_src, req_addr,
                  req_write ? req_wdata : '0,
                  req_write ? req_be    : '0};

  // order store
  ctq_order_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (acc),
    .pdata  (pdata),
    .pop    (pop),
    .head   (head),
    .nempty (nempty),
    .full   (full)
  );

  assign dsp_valid = nempty;
  assign {dsp_write, dsp_src, dsp_addr, dsp_wdata, dsp_be} = head;
  assign dsp_beats = dsp_write ? LEN_W'(WR_BEATS) : LEN_W'(RD_BEATS);
  assign pop   = dsp_valid && dsp_ready;
  assign pop_w = pop && dsp_write;

  always_ff @(posedge clk) begin
    if (!rst_n) wcnt <= '0;
    else        wcnt <= wcnt + WCW'(acc_w) - WCW'(pop_w);
  end

  // read credits and beat counting
  assign rsp_valid     = ctl_rsp_valid;
  assign rsp_data      = ctl_rsp_data;
  assign rsp_src       = ctl_rsp_src;
  assign ctl_rsp_ready = rsp_ready;
  assign rsp_fire      = ctl_rsp_valid && rsp_ready;
  assign rsp_last      = last_beat;

  ctq_read_credit #(.RD_BEATS(RD_BEATS), .CW(RCW)) u_credit (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc_r),
    .acc_src  (req_src),
    .rsp_fire (rsp_fire),
    .rsp_src  (ctl_rsp_src),
    .room     (room),
    .last     (last_beat)
  );

  // distinct-line tracking for data-cache loads
  assign free_line = rsp_fire && last_beat && (ctl_rsp_src == SRC_DLOAD);

  ctq_line_track #(.LW(LW), .SLOTS(src_quota(0))) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc      (acc_r && req_src == SRC_DLOAD),
    .alloc_line (req_addr[ADDR_W-1:LINE_SH]),
    .free       (free_line),
    .probe_line (req_addr[ADDR_W-1:LINE_SH]),
    .hit        (line_hit)
  );

  // R2
  wr_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WCW'(WR_SLOTS));
  // R8
  dsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=>
      (dsp_valid && $stable(dsp_addr) && $stable(dsp_src) && $stable(dsp_write)));
endmodule

// File: tb/cpu_txn_queue_tb_top.sv
`timescale 1ns/1ps
module cpu_txn_queue_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 0, req_write = 0;
  logic [1:0]   req_src = 0;
  logic [31:0]  req_addr = 0;
  logic [127:0] req_wdata = 0;
  logic [15:0]  req_be = 0;
  logic         req_ready;
  logic         dsp_valid, dsp_write;
  logic         dsp_ready = 0;
  logic [1:0]   dsp_src;
  logic [31:0]  dsp_addr;
  logic [127:0] dsp_wdata;
  logic [15:0]  dsp_be;
  logic [3:0]   dsp_beats;
  logic         ctl_rsp_valid = 0, ctl_rsp_ready;
  logic [31:0]  ctl_rsp_data = 0;
  logic [1:0]   ctl_rsp_src = 0;
  logic         rsp_valid, rsp_last;
  logic         rsp_ready = 0;
  logic [31:0]  rsp_data;
  logic [1:0]   rsp_src;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpu_txn_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_write(dsp_write),
    .dsp_src(dsp_src), .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata), .dsp_be(dsp_be),
    .dsp_beats(dsp_beats),
    .ctl_rsp_valid(ctl_rsp_valid), .ctl_rsp_ready(ctl_rsp_ready),
    .ctl_rsp_data(ctl_rsp_data), .ctl_rsp_src(ctl_rsp_src),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_src(rsp_src), .rsp_last(rsp_last)
  );

  typedef struct {
    bit         w;
    bit [1:0]   s;
    bit [31:0]  a;
    bit [127:0] d;
    bit [15:0]  b;
  } ent_t;

  ent_t     oq[$];
  bit [1:0] pend[$];
  bit [26:0] dl[$];
  int wcnt = 0;
  int rc[4] = '{0, 0, 0, 0};
  int bc[4] = '{0, 0, 0, 0};

  function automatic int quota(input bit [1:0] s);
    return (s == 0) ? 4 : (s == 1) ? 2 : 1;
  endfunction

  function automatic bit line_busy(input bit [26:0] ln);
    foreach (dl[i]) if (dl[i] == ln) return 1;
    return 0;
  endfunction

  function automatic bit exp_ready(input bit w, input bit [1:0] s, input bit [31:0] a);
    if (w) return wcnt < 8;
    return (rc[s] < quota(s)) && !(s == 0 && line_busy(a[31:5]));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit eb, acc, pf, rf;
    ent_t e;
    int phase, cyc;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    req_valid = 0; req_write = 1; #1;
    chk(req_ready === 1'b1, "R1", "write ready after reset", req_ready, 1);
    req_write = 0;
    for (int s = 0; s < 4; s++) begin
      req_src = 2'(s); #1;
      chk(req_ready === 1'b1, "R1", "read ready after reset", req_ready, 1);
    end
    chk(dsp_valid === 1'b0, "R1", "dispatch idle after reset", dsp_valid, 0);

    for (cyc = 0; cyc < 4000; cyc++) begin
      phase = (cyc < 30) ? 0 : (cyc < 90) ? 1 : (cyc < 600) ? 3 : 2;
      @(negedge clk);
      // drive stimulus
      req_valid = ($urandom_range(0, 99) < 70);
      case (phase)
        0: req_write = 1;
        1: req_write = 0;
        default: req_write = ($urandom_range(0, 99) < 45);
      endcase
      req_src = (phase == 3) ? 2'd0 : 2'($urandom_range(0, 3));
      req_addr = (phase == 3) ? {24'h0, 3'($urandom_range(0, 5)), 5'($urandom)}
                              : {24'h0, 3'($urandom_range(0, 7)), 5'($urandom)};
      req_wdata = {$urandom, $urandom, $urandom, $urandom};
      req_be = 16'($urandom);
      dsp_ready = (phase < 2) ? 1'b0 : ($urandom_range(0, 99) < 65);
      rsp_ready = ($urandom_range(0, 99) < 80);
      if (pend.size() > 0 && $urandom_range(0, 99) < 70) begin
        ctl_rsp_valid = 1;
        ctl_rsp_src = pend[0];
      end else begin
        ctl_rsp_valid = 0;
        ctl_rsp_src = 2'($urandom);
      end
      ctl_rsp_data = $urandom;
      #1;
      // request acceptance
      eb = exp_ready(req_write, req_src, req_addr);
      if (req_write)
        chk(req_ready === eb, "R2", "write ready vs slot count", req_ready, eb);
      else if (req_src == 0 && line_busy(req_addr[31:5]) && rc[0] < 4)
        chk(req_ready === eb, "R5", "data load line clash", req_ready, eb);
      else
        chk(req_ready === eb, "R3", "read ready vs source quota", req_ready, eb);
      // dispatch
      chk(dsp_valid === (oq.size() > 0), "R6", "dispatch valid", dsp_valid, oq.size() > 0);
      if (oq.size() > 0 && dsp_valid) begin
        e = oq[0];
        chk(dsp_write === e.w && dsp_src === e.s && dsp_addr === e.a, "R6",
            "dispatch order head", {dsp_write, dsp_src, dsp_addr}, {e.w, e.s, e.a});
        chk(dsp_wdata === e.d && dsp_be === e.b, "R7", "dispatch data/enables",
            dsp_wdata ^ e.d, 0);
        chk(dsp_beats === (e.w ? 4'd4 : 4'd8), "R7", "dispatch beat count",
            dsp_beats, e.w ? 4 : 8);
      end
      // response path
      chk(rsp_valid === ctl_rsp_valid && ctl_rsp_ready === rsp_ready, "R9",
          "response handshake passthrough", {rsp_valid, ctl_rsp_ready},
          {ctl_rsp_valid, rsp_ready});
      if (ctl_rsp_valid) begin
        chk(rsp_data === ctl_rsp_data && rsp_src === ctl_rsp_src, "R9",
            "response data/tag", {rsp_src, rsp_data}, {ctl_rsp_src, ctl_rsp_data});
        chk(rsp_last === (bc[ctl_rsp_src] == 7), "R4", "last beat flag",
            rsp_last, bc[ctl_rsp_src] == 7);
      end
      acc = req_valid && eb;
      pf  = dsp_valid && dsp_ready && oq.size() > 0;
      rf  = ctl_rsp_valid && rsp_ready;
      @(posedge clk);
      // update model
      if (pf) begin
        e = oq.pop_front();
        if (e.w) wcnt--; else pend.push_back(e.s);
      end
      if (rf) begin
        bc[ctl_rsp_src]++;
        if (bc[ctl_rsp_src] == 8) begin
          bc[ctl_rsp_src] = 0;
          rc[ctl_rsp_src]--;
          void'(pend.pop_front());
          if (ctl_rsp_src == 0) void'(dl.pop_front());
        end
      end
      if (acc) begin
        e.w = req_write; e.s = req_src; e.a = req_addr;
        e.d = req_write ? req_wdata : '0;
        e.b = req_write ? req_be : '0;
        oq.push_back(e);
        if (req_write) wcnt++;
        else begin
          rc[req_src]++;
          if (req_src == 0) dl.push_back(req_addr[31:5]);
        end
      end
    end

    // R8: stalled dispatch holds payload
    @(negedge clk);
    req_valid = 0; ctl_rsp_valid = 0; dsp_ready = 0;
    req_write = 1; req_addr = 32'h40; req_valid = 1; #1;
    acc = req_ready;
    @(posedge clk);
    if (acc) begin
      e.w = 1; e.s = req_src; e.a = 32'h40; e.d = req_wdata; e.b = req_be;
      oq.push_back(e);
    end
    @(negedge clk);
    req_valid = 0; #1;
    e = oq[0];
    @(negedge clk); #1;
    chk(dsp_valid === 1'b1 && dsp_addr === e.a && dsp_src === e.s, "R8",
        "stalled dispatch holds", {dsp_valid, dsp_addr}, {1'b1, e.a});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule